// File: doc/BRIEF.md
# Latched Diagnostic Status Output

This block drives one active-high status pin that tells a host controller about output-stage faults and about malformed serial command frames. It watches the same active-low select line and serial clock that the command interface uses, and keeps its own count of clock falls in each frame. Frames are bounded by select going low and coming back high. The serial clock idles high, and every clock is a fall followed by a rise.

Three events are held in latches: a frame that ended with too few clocks, a frame that ran past the expected bit count, and an overtemperature report. Each latch is released at a different clock fall of a later frame. A host that keeps clocking and watches when the pin drops can therefore tell which fault was recorded. Live per-stage short-circuit flags and the live overtemperature flag are ORed straight onto the pin. A self-test request can force the pin high, but only while the command block reports standby.

Both serial lines are brought into the system clock domain through synchroniser chains before any edge is detected. The reset is synchronous and active high.

Top module: `diag_status`

## Requirements
- R1: While reset is held and right after it is released, status_o is 0 and all latches are clear.
- R2: Any bit of short_i, or overtemp_i, set to 1 drives status_o to 1 one system clock later. Status is the OR of all sources.
- R3: When select rises after fewer than 8 clock falls in the frame (including zero), an underflow latch is set and status_o goes high.
- R4: The underflow latch clears on the 8th clock fall of a later frame. Status stays high after falls 1 to 7.
- R5: In a frame with more than 8 clocks, the overflow latch is set by the rise of the 9th clock. Status is still low after the 9th fall and high after the 9th rise.
- R6: The overflow latch clears on the 2nd clock fall of a later frame. Status is still high after the 1st fall.
- R7: Overtemperature is latched. Status stays high after overtemp_i returns to 0.
- R8: The overtemperature latch clears on the 4th clock fall of a frame only if overtemp_i is 0 at that moment. Otherwise it stays set.
- R9: A frame with exactly 8 clocks sets neither the underflow latch nor the overflow latch.
- R10: selftest_i drives status_o high only while standby_i is 1. Otherwise it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Frame select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, idles high, asynchronous |
| short_i | input | N_STAGES | Live short-circuit flags, one per output stage |
| overtemp_i | input | 1 | Live overtemperature flag |
| standby_i | input | 1 | Standby indication from the command block |
| selftest_i | input | 1 | Self-test request for the status pin |
| status_o | output | 1 | Registered diagnostic status, active high |

## Verification
A change on sel_n_i or sclk_i reaches status_o after four system clock edges. These are two synchroniser stages, then the edge register feeding the latch or counter, then the output register. The bench therefore drives each serial edge on a falling system clock and samples six cycles later, after the result has settled and before the next serial edge. The live inputs short_i, overtemp_i and selftest_i reach the pin after one edge, and the bench samples them two falling system clocks after driving them. Clear points are checked after every individual clock fall of the releasing frame, so a clear that comes one count early or one count late is caught.

// File: rtl/diag_status_pkg.sv
package diag_status_pkg;
  // Synchronised view of one asynchronous pin
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } pin_evt_t;

  // Index of each latched event
  localparam int LAT_UF = 0;
  localparam int LAT_OF = 1;
  localparam int LAT_OT = 2;
  localparam int LAT_N  = 3;
endpackage

// File: rtl/diag_sync_edge.sv
module diag_sync_edge
  import diag_status_pkg::*;
#(
  parameter int STAGES = 2,
  parameter bit IDLE   = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     pin_i,
  output pin_evt_t evt_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              synced;

  assign synced = chain_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{IDLE}};
      prev_q  <= IDLE;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= synced;
    end
  end

  assign evt_o.level = synced;
  assign evt_o.rise  = synced & ~prev_q;
  assign evt_o.fall  = ~synced & prev_q;
endmodule

// File: rtl/diag_frame_cnt.sv
module diag_frame_cnt
  import diag_status_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  localparam int CNT_W     = $clog2(FRAME_BITS + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  pin_evt_t         sel_e,
  input  pin_evt_t         sck_e,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS + 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (sel_e.fall) begin
      cnt_o <= '0;
    end else if (sck_e.fall && !sel_e.level && cnt_o != CNT_MAX) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    sel_e.fall |=> (cnt_o == '0)); // R3
endmodule

// File: rtl/diag_event_latch.sv
module diag_event_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/diag_status.sv
module diag_status
  import diag_status_pkg::*;
#(
  parameter int N_STAGES    = 4,
  parameter int FRAME_BITS  = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CLR_UF_AT   = 8,
  parameter int CLR_OF_AT   = 2,
  parameter int CLR_OT_AT   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_n_i,
  input  logic                sclk_i,
  input  logic [N_STAGES-1:0] short_i,
  input  logic                overtemp_i,
  input  logic                standby_i,
  input  logic                selftest_i,
  output logic                status_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] C_FULL = CNT_W'(FRAME_BITS);

  pin_evt_t         sel_e, sck_e;
  logic [CNT_W-1:0] cnt;
  logic             in_frame, clk_fall_in;
  logic [CNT_W-1:0] cnt_next;
  logic [LAT_N-1:0] lat_set, lat_clr, lat_q;

  diag_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sel_sync (
    .clk(clk), .rst(rst), .pin_i(sel_n_i), .evt_o(sel_e));
  diag_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sck_sync (
    .clk(clk), .rst(rst), .pin_i(sclk_i), .evt_o(sck_e));

  diag_frame_cnt #(.FRAME_BITS(FRAME_BITS)) u_cnt (
    .clk(clk), .rst(rst), .sel_e(sel_e), .sck_e(sck_e), .cnt_o(cnt));

  assign in_frame    = ~sel_e.level;
  assign clk_fall_in = sck_e.fall & in_frame;
  assign cnt_next    = cnt + 1'b1;

  always_comb begin
    lat_set         = '0;
    lat_clr         = '0;
    lat_set[LAT_UF] = sel_e.rise & (cnt < C_FULL);
    lat_set[LAT_OF] = sck_e.rise & in_frame & (cnt > C_FULL);
    lat_set[LAT_OT] = overtemp_i;
    lat_clr[LAT_UF] = clk_fall_in & (cnt_next == CNT_W'(CLR_UF_AT));
    lat_clr[LAT_OF] = clk_fall_in & (cnt_next == CNT_W'(CLR_OF_AT));
    lat_clr[LAT_OT] = clk_fall_in & (cnt_next == CNT_W'(CLR_OT_AT)) & ~overtemp_i;
  end

  for (genvar g = 0; g < LAT_N; g++) begin : g_lat
    diag_event_latch u_lat (
      .clk(clk), .rst(rst), .set_i(lat_set[g]), .clr_i(lat_clr[g]), .q_o(lat_q[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) status_o <= 1'b0;
    else     status_o <= (|short_i) | overtemp_i | (|lat_q) | (standby_i & selftest_i);
  end

  AST_LIVE_OR: assert property (@(posedge clk) disable iff (rst)
    ((|short_i) || overtemp_i) |=> status_o); // R2
  AST_UF_SET: assert property (@(posedge clk) disable iff (rst)
    (sel_e.rise && cnt < C_FULL) |=> lat_q[LAT_UF]); // R3
  AST_OF_SET: assert property (@(posedge clk) disable iff (rst)
    (sck_e.rise && in_frame && cnt > C_FULL) |=> lat_q[LAT_OF]); // R5
  AST_EXACT_FRAME: assert property (@(posedge clk) disable iff (rst)
    (sel_e.rise && cnt == C_FULL && !lat_q[LAT_UF]) |=> !lat_q[LAT_UF]); // R9
  AST_OT_KEEP: assert property (@(posedge clk) disable iff (rst)
    (lat_q[LAT_OT] && overtemp_i) |=> lat_q[LAT_OT]); // R8
  AST_TEST_GATED: assert property (@(posedge clk) disable iff (rst)
    (!standby_i && selftest_i && short_i == '0 && !overtemp_i && lat_q == '0
     && lat_set == '0) |=> !status_o); // R10
endmodule

// File: tb/diag_status_bench.sv
module diag_status_bench;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_n = 1'b1, sclk = 1'b1, ot = 1'b0, stby = 1'b0, stest = 1'b0;
  logic [NS-1:0] shrt = '0;
  logic          status;
  int            nchk = 0, nerr = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  diag_status #(.N_STAGES(NS)) u_diag_status (
    .clk(clk), .rst(rst), .sel_n_i(sel_n), .sclk_i(sclk), .short_i(shrt),
    .overtemp_i(ot), .standby_i(stby), .selftest_i(stest), .status_o(status));

  task automatic chk(input logic exp, input string req);
    nchk++;
    if (status !== exp) begin
      nerr++;
      $display("FAIL %s: status=%0b expected %0b", req, status, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_sel(input logic v);
    @(negedge clk); sel_n = v; wait_n(6);
  endtask
  task automatic drive_sck(input logic v);
    @(negedge clk); sclk = v; wait_n(6);
  endtask

  // Plain frame with n clocks, no checks
  task automatic frame(input int n);
    drive_sel(1'b0);
    for (int i = 1; i <= n; i++) begin drive_sck(1'b0); drive_sck(1'b1); end
    drive_sel(1'b1);
  endtask

  initial begin
    wait_n(4);
    chk(1'b0, "R1 in reset");
    rst = 1'b0;
    wait_n(3);
    chk(1'b0, "R1 after reset");

    // Sweep of clock counts 0..11 (R3, R5, R9)
    for (int n = 0; n <= 11; n++) begin
      frame(8);
      chk(1'b0, "R9 clean frame");
      drive_sel(1'b0);
      for (int i = 1; i <= n; i++) begin
        drive_sck(1'b0);
        if (i == 9) chk(1'b0, "R5 after 9th fall");
        drive_sck(1'b1);
        if (i == 9) chk(1'b1, "R5 after 9th rise");
      end
      drive_sel(1'b1);
      if (n < 8)       chk(1'b1, "R3 short frame");
      else if (n == 8) chk(1'b0, "R9 exact frame");
      else             chk(1'b1, "R5 long frame");
    end

    // Underflow release at 8th fall (R4)
    frame(8); frame(3);
    chk(1'b1, "R3 set");
    drive_sel(1'b0);
    for (int i = 1; i <= 8; i++) begin
      drive_sck(1'b0);
      chk(i < 8, "R4 underflow clear point");
      drive_sck(1'b1);
    end
    drive_sel(1'b1);

    // Overflow release at 2nd fall (R6)
    frame(10);
    chk(1'b1, "R5 set");
    drive_sel(1'b0);
    for (int i = 1; i <= 8; i++) begin
      drive_sck(1'b0);
      chk(i < 2, "R6 overflow clear point");
      drive_sck(1'b1);
    end
    drive_sel(1'b1);
    chk(1'b0, "R6 cleared");

    // Live short flags (R2)
    for (int b = 0; b < NS; b++) begin
      @(negedge clk); shrt = NS'(1) << b; wait_n(2);
      chk(1'b1, "R2 short bit");
      @(negedge clk); shrt = '0; wait_n(2);
      chk(1'b0, "R2 short removed");
    end

    // Overtemperature latch (R2, R7, R8)
    @(negedge clk); ot = 1'b1; wait_n(2);
    chk(1'b1, "R2 live overtemp");
    @(negedge clk); ot = 1'b0; wait_n(3);
    chk(1'b1, "R7 overtemp latched");
    drive_sel(1'b0);
    for (int i = 1; i <= 8; i++) begin
      drive_sck(1'b0);
      chk(i < 4, "R8 overtemp clear point");
      drive_sck(1'b1);
    end
    drive_sel(1'b1);
    @(negedge clk); ot = 1'b1; wait_n(2);
    drive_sel(1'b0);
    for (int i = 1; i <= 8; i++) begin
      drive_sck(1'b0);
      if (i == 4) chk(1'b1, "R8 still hot at 4th fall");
      drive_sck(1'b1);
    end
    drive_sel(1'b1);
    @(negedge clk); ot = 1'b0; wait_n(3);
    chk(1'b1, "R8 kept after hot clear point");
    frame(8);
    chk(1'b0, "R8 cleared when cool");

    // Self-test gating (R10)
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); stby = m[0]; stest = m[1]; wait_n(2);
      chk(m == 3, "R10 self-test gating");
    end
    @(negedge clk); stby = 1'b0; stest = 1'b0; wait_n(2);
    chk(1'b0, "R10 released");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule